// File: doc/BRIEF.md
# Programmable Digital Phase-Locked Loop Core

This block is a fully digital phase-locked loop. A phase accumulator, clocked by the system clock, acts as a numerically controlled oscillator. It is steered so that its wrap-around lines up with a divided version of an external reference edge. The reference edge arrives already synchronized to the system clock as a one-cycle pulse. An integer pre-divider counts these pulses and raises a comparison event on every Nth one. At each comparison event:

- the accumulator value is taken as the phase error;
- a proportional-plus-integral filter turns that error into a frequency correction;
- the oscillator's increment is reloaded as the nominal frequency word plus that correction.

Every loop property is a number supplied at runtime: the divide ratio, the two gains (given as right-shift amounts), the lock window and the lock qualification count. A system can therefore keep the same loop dynamics across reference rates that differ by orders of magnitude. Large shift values give very small effective gains, and so very narrow loop bandwidths. The synthesized clock is the most significant bit of the accumulator. The full phase word is also exported for a downstream waveform stage.

The accumulator may wrap several times between comparison events. The feedback division ratio is therefore set by the nominal word and the comparison interval, and no separate counter is needed.

Top module: `dpll_core`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator clears to 0, `locked` clears, the integrator clears and the increment loads `nom_word`. On the first clock after reset the phase therefore equals `nom_word`.
- R2: On every clock out of reset, `phase` advances by the current increment, modulo 2^PW. `clk_out` equals bit PW-1 of `phase`.
- R3: A comparison event happens on a `ref_edge` pulse that completes a group of N pulses, where N is `ref_div`; a value of 0 acts as 1. Pulses that do not complete a group change neither the increment nor the lock state.
- R4: At a comparison event, the phase error is the two's-complement negation of `phase` as it stood before that clock, with `phase` read as a signed PW-bit value.
- R5: The proportional term is the error arithmetically shifted right by `kp_shift`. The integrator increment is the error arithmetically shifted right by `ki_shift`.
- R6: The integrator saturates at +(2^(PW-1)-1) and -2^(PW-1) instead of wrapping.
- R7: At a comparison event, the increment becomes `nom_word` plus the updated integrator plus the proportional term, modulo 2^PW, and the new increment takes effect from the next clock. Changes to `nom_word` between comparison events have no effect until the next event.
- R8: `locked` rises at the comparison event that completes max(`lock_count`,1) consecutive events whose absolute error is strictly below `lock_thresh`.
- R9: `locked` falls at the first comparison event whose absolute error is at least `lock_thresh`. That event also restarts the qualification count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_edge | input | 1 | One-cycle pulse per reference edge, already synchronized |
| ref_div | input | DW | Reference pre-divide ratio (0 acts as 1) |
| nom_word | input | PW | Nominal frequency increment |
| kp_shift | input | SW | Proportional gain as a right shift |
| ki_shift | input | SW | Integral gain as a right shift |
| lock_thresh | input | PW | Absolute phase error window for lock |
| lock_count | input | CW | Consecutive in-window comparisons needed for lock |
| phase | output | PW | Oscillator phase word |
| clk_out | output | 1 | Synthesized clock, the phase MSB |
| locked | output | 1 | Lock indicator |

## Verification
Two situations put events in the same cycle.

The first is a comparison event on a clock where the accumulator is also wrapping. The increment reload and the accumulator step then meet, and the error must come from the phase as it stood before that clock. The bench provokes this by running the loop with the comparison interval an exact multiple of the wrap period. It judges the result against its own behavioural model on every clock.

The second is the lock decision meeting an integrator that sits at its saturation limit. This is provoked with an integral shift of zero and a badly offset nominal word. Directed pulse sequences then settle exact lock rise and fall points with all-pass and no-pass windows.

// File: rtl/dpll_core.sv
module dpll_core #(
  parameter int PW = 24,
  parameter int DW = 12,
  parameter int SW = 5,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_edge,
  input  logic [DW-1:0] ref_div,
  input  logic [PW-1:0] nom_word,
  input  logic [SW-1:0] kp_shift,
  input  logic [SW-1:0] ki_shift,
  input  logic [PW-1:0] lock_thresh,
  input  logic [CW-1:0] lock_count,
  output logic [PW-1:0] phase,
  output logic          clk_out,
  output logic          locked
);
  localparam int EW = PW + 1;
  localparam logic signed [EW-1:0] IMAX = {2'b00, {(PW-1){1'b1}}};
  localparam logic signed [EW-1:0] IMIN = {2'b11, {(PW-1){1'b0}}};

  logic [DW-1:0] rcnt, rlast;
  logic [PW-1:0] tune;
  logic [CW-1:0] lcnt, lneed;
  logic signed [EW-1:0] err, integ, isum, inext, pterm, filt;
  logic [EW-1:0] err_abs;
  logic cmp, in_win;

  assign rlast   = (ref_div == '0) ? '0 : ref_div - 1'b1;
  assign cmp     = ref_edge && (rcnt >= rlast);
  assign err     = -$signed({phase[PW-1], phase});
  assign err_abs = err[EW-1] ? -err : err;
  assign pterm   = err >>> kp_shift;
  assign isum    = integ + (err >>> ki_shift);
  assign inext   = (isum > IMAX) ? IMAX : (isum < IMIN) ? IMIN : isum;
  assign filt    = inext + pterm;
  assign in_win  = err_abs < {1'b0, lock_thresh};
  assign lneed   = (lock_count == '0) ? CW'(1) : lock_count;
  assign clk_out = phase[PW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      tune   <= nom_word;
      integ  <= '0;
      rcnt   <= '0;
      lcnt   <= '0;
      locked <= 1'b0;
    end else begin
      phase <= phase + tune;
      if (ref_edge) rcnt <= cmp ? '0 : rcnt + 1'b1;
      if (cmp) begin
        integ <= inext;
        tune  <= nom_word + filt[PW-1:0];
        if (in_win) begin
          if (lcnt != '1) lcnt <= lcnt + 1'b1;
          if (({1'b0, lcnt} + 1'b1) >= {1'b0, lneed}) locked <= 1'b1;
        end else begin
          lcnt   <= '0;
          locked <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dpll_core_chk.sv
module dpll_core_chk #(
  parameter int PW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          cmp,
  input logic [PW-1:0] tune,
  input logic [PW-1:0] phase,
  input logic [PW:0]   err_abs,
  input logic [PW-1:0] lock_thresh,
  input logic [PW-1:0] nom_word,
  input logic          locked
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (phase == '0 && !locked && tune == $past(nom_word)));
  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phase == PW'($past(phase) + $past(tune)));
  // R7
  tune_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cmp |=> $stable(tune));
  // R8
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(cmp));
  // R9
  unlock_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp && err_abs >= {1'b0, lock_thresh}) |=> !locked);
endmodule

bind dpll_core dpll_core_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst(rst), .cmp(cmp), .tune(tune), .phase(phase),
  .err_abs(err_abs), .lock_thresh(lock_thresh), .nom_word(nom_word),
  .locked(locked)
);

// File: tb/test_dpll_core.sv
module test_dpll_core;
  localparam int CLK = 10;
  localparam int PW = 24, DW = 12, SW = 5, CW = 8;
  localparam longint M = longint'(1) << PW;
  localparam longint HALF = longint'(1) << (PW - 1);

  logic clk = 0, rst = 1, ref_edge = 0;
  logic [DW-1:0] ref_div = 1;
  logic [PW-1:0] nom_word = 24'd524288, lock_thresh = '1;
  logic [SW-1:0] kp_shift = 3, ki_shift = 7;
  logic [CW-1:0] lock_count = 3;
  logic [PW-1:0] phase;
  logic clk_out, locked;

  int total = 0, bad = 0, ecnt = 0;
  bit go = 0, done = 0;
  string cur = "R1";

  longint m_phase = 0, m_tune = 0, m_integ = 0, m_rcnt = 0, m_lcnt = 0;
  bit m_locked = 0;

  always #(CLK/2) clk = ~clk;

  dpll_core #(.PW(PW), .DW(DW), .SW(SW), .CW(CW)) i_dpll_core (
    .clk(clk), .rst(rst), .ref_edge(ref_edge), .ref_div(ref_div),
    .nom_word(nom_word), .kp_shift(kp_shift), .ki_shift(ki_shift),
    .lock_thresh(lock_thresh), .lock_count(lock_count),
    .phase(phase), .clk_out(clk_out), .locked(locked));

  task automatic chk(string req, longint got, longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // behavioural reference, advanced once per clock
  always @(posedge clk) begin
    longint last, ps, e, ea, nx, f, need;
    bit fire;
    if (rst) begin
      m_phase = 0; m_tune = nom_word; m_integ = 0;
      m_rcnt = 0; m_lcnt = 0; m_locked = 0;
    end else begin
      last = (ref_div == 0) ? 0 : longint'(ref_div) - 1;
      fire = ref_edge && (m_rcnt >= last);
      ps = (m_phase >= HALF) ? m_phase - M : m_phase;
      e  = -ps;
      ea = (e < 0) ? -e : e;
      m_phase = (m_phase + m_tune) % M;
      if (ref_edge) m_rcnt = fire ? 0 : m_rcnt + 1;
      if (fire) begin
        nx = m_integ + (e >>> ki_shift);
        if (nx > HALF - 1) nx = HALF - 1;
        if (nx < -HALF) nx = -HALF;
        m_integ = nx;
        f = nx + (e >>> kp_shift);
        m_tune = ((longint'(nom_word) + f) % M + M) % M;
        need = (lock_count == 0) ? 1 : longint'(lock_count);
        if (ea < longint'(lock_thresh)) begin
          if (m_lcnt + 1 >= need) m_locked = 1;
          if (m_lcnt < (1 << CW) - 1) m_lcnt = m_lcnt + 1;
        end else begin
          m_lcnt = 0; m_locked = 0;
        end
      end
    end
  end

  always @(negedge clk) if (go) begin
    chk({cur, " phase"}, phase, m_phase);
    chk({cur, " clk_out R2"}, clk_out, m_phase >= HALF);
    chk({cur, " locked"}, locked, m_locked);
  end

  task automatic run(int n, int per);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ecnt++;
      ref_edge = (per > 0) && (ecnt % per == 0);
    end
    @(negedge clk); ref_edge = 0;
  endtask

  task automatic pulse();
    @(negedge clk); ref_edge = 1;
    @(negedge clk); ref_edge = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; ref_edge = 0;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  initial begin
    #(CLK * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    go = 1;
    // R1 reset state and first step
    cur = "R1"; nom_word = 24'd1000;
    @(negedge clk); rst = 0;
    chk("R1 phase after reset", phase, 0);
    chk("R1 locked after reset", locked, 0);
    @(negedge clk);
    chk("R1 first step equals nom_word", phase, 1000);

    // R8 lock after lock_count in-window comparisons
    cur = "R8"; ref_div = 1; lock_thresh = '1; lock_count = 3; nom_word = 24'd777;
    do_reset();
    pulse(); pulse();
    chk("R8 not locked after 2", locked, 0);
    pulse();
    chk("R8 locked after 3", locked, 1);
    // R9 first out-of-window comparison clears lock
    cur = "R9"; lock_thresh = '0;
    pulse();
    chk("R9 cleared", locked, 0);
    // R8 lock_count 0 acts as 1
    cur = "R8"; lock_thresh = '1; lock_count = 0;
    pulse();
    chk("R8 count zero locks at once", locked, 1);

    // R3 divider: only every third pulse compares
    cur = "R3"; ref_div = 3; lock_count = 1;
    do_reset();
    pulse(); pulse();
    chk("R3 no compare on pulses 1-2", locked, 0);
    pulse();
    chk("R3 compare on third pulse", locked, 1);
    ref_div = 0; lock_thresh = '0;
    pulse();
    chk("R3 ratio zero compares every pulse", locked, 0);

    // R4 R5 R7 closed loop, comparison every 32 clocks, exact wrap multiple
    cur = "R4 R5 R7"; ref_div = 4; kp_shift = 3; ki_shift = 7;
    lock_thresh = 24'd4000; lock_count = 4; nom_word = 24'd524288 + 24'd300;
    do_reset(); ecnt = 0;
    run(1500, 8);
    cur = "R7 nom change"; nom_word = 24'd524288 - 24'd900;
    run(1500, 8);

    // R6 saturating integrator with full integral gain
    cur = "R6"; kp_shift = 31; ki_shift = 0; nom_word = 24'h7FFFFF;
    lock_thresh = 24'd100; lock_count = 2;
    do_reset(); ecnt = 0;
    run(2000, 5);
    ki_shift = 1; kp_shift = 0; nom_word = 24'h100;
    run(2000, 7);

    // R3 large ratio, slow comparison rate
    cur = "R3 div1944"; ref_div = 12'd1944; kp_shift = 2; ki_shift = 9;
    nom_word = 24'd4321; lock_thresh = 24'd2000000; lock_count = 2;
    do_reset(); ecnt = 0;
    run(20000, 2);

    go = 0; done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule